// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off state of a crosspoint switch matrix with 4 rows and 8 columns. Each of the 32 crosspoints has one control cell. A write names one cell with a row select and a column select, drives the new level on a data line, and qualifies the write with an active-high chip select and an active-high write strobe. Cells behave as transparent latches. While chip select and strobe are both high, the addressed cell shows the data line at its output. When the strobe falls, the cell keeps the level that data had at that moment.

An active-high master reset clears every cell at once, whatever the chip select level. Because chip select gates every write, several copies can share the address, data and strobe wires and build a larger matrix. The outputs are a flat 32-bit enable vector and a row-by-column view of the same bits, which drive the external switches.

The control inputs are asynchronous to the system clock. They pass through a synchronizer chain of `SYNC_STAGES` flops before any decision is made. A small write controller has three states:

- ST_CLEAR: held while reset or its synchronized release is active.
- ST_IDLE: waiting for a write.
- ST_OPEN: the addressed cell is transparent.

Its transitions are:

- any state to ST_CLEAR on reset.
- ST_CLEAR to ST_IDLE once the synchronized reset has gone low.
- ST_IDLE to ST_OPEN when synchronized strobe and chip select are both high.
- ST_OPEN stays in ST_OPEN while both remain high.
- ST_OPEN to ST_IDLE when the strobe falls. This is the capture step: the synchronized data of that cycle is stored.
- ST_OPEN to ST_IDLE when chip select drops with the strobe still high. This is the close step: the cell keeps the last level it followed.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: An active-high `rst` clears all 32 cells to 0 asynchronously, regardless of `cs`, and `sw_en` reads all zeros while `rst` is high. After `rst` falls, no write is accepted until the synchronized reset has released.
- R2: The cell index is `row_sel*8 + col_sel`, which is bit `{row_sel,col_sel}` of `sw_en`. For example, row 0 column 0 is bit 0, row 0 column 1 is bit 1, row 0 column 4 is bit 4 and row 1 column 0 is bit 8. `sw_grid[r][c]` always equals `sw_en[r*8+c]`.
- R3: A cell is written only when its address matches, `strobe` is high and `cs` is high, with reset released. In every other case all cells keep their values.
- R4: While `strobe` and `cs` are both high, the output bit of the addressed cell follows `data`, including changes of `data` during the strobe.
- R5: The value a cell holds after the strobe falls is the level of `data` at the falling edge of `strobe`.
- R6: A write changes only the addressed cell, and every other cell keeps its previous value.
- R7: A stored 1 drives its `sw_en` bit high (crosspoint on), and a stored 0 drives it low (crosspoint off).
- R8: With `cs` low, `strobe` and `data` have no effect on any cell, so several blocks can share the address, data and strobe lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the control lines |
| rst | input | 1 | Master clear, active high, asynchronous assert |
| strobe | input | 1 | Write strobe, active high; the falling edge captures data |
| cs | input | 1 | Chip select, active high; qualifies every write |
| data | input | 1 | Level written into the addressed cell (1 = switch on) |
| row_sel | input | ROW_BITS | Row of the addressed crosspoint |
| col_sel | input | COL_BITS | Column of the addressed crosspoint |
| sw_en | output | 2**(ROW_BITS+COL_BITS) | Switch enables, bit index row*COLS+col |
| sw_grid | output | ROWS x COLS | Same enables viewed as [row][col] |

## Verification
The bench builds the block with its defaults: two row bits, three column bits and a two-flop synchronizer. This keeps the whole 32-cell array small enough to sweep every address and compare the complete enable vector after each write. With these values, the tests reach:

- transparency while data toggles under a held strobe.
- the captured level at the strobe fall, for both ending values.
- writes masked by a low chip select.
- a reset that lands in the middle of an open strobe.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_OPEN  = 2'd2
    } wr_state_e;

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) begin
                pipe[k] <= pipe[k-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/xpt_rst_sync.sv
module xpt_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic srst
);
    logic [STAGES-1:0] hold;

    // Asserts at once, releases after STAGES clean clock edges.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hold <= '1;
        end else begin
            hold <= {hold[STAGES-2:0], 1'b0};
        end
    end

    assign srst = hold[STAGES-1];
endmodule

// File: rtl/xpt_write_fsm.sv
module xpt_write_fsm import xpt_pkg::*; #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  logic             s_strobe,
    input  logic             s_cs,
    input  logic             s_data,
    input  logic [IDX_W-1:0] s_idx,
    output logic             track,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_data
);
    wr_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             commit;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Address of the cell currently held open
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            idx_q <= '0;
        end else if (track) begin
            idx_q <= s_idx;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (!srst) state_d = ST_IDLE;
            ST_IDLE:  if (s_strobe && s_cs) state_d = ST_OPEN;
            ST_OPEN:  if (!s_strobe || !s_cs) state_d = ST_IDLE;
            default:  state_d = ST_CLEAR;
        endcase
        if (srst) state_d = ST_CLEAR;
    end

    // Outputs
    always_comb begin
        track   = (state_q != ST_CLEAR) && s_strobe && s_cs;
        commit  = (state_q == ST_OPEN) && !s_strobe;
        wr_en   = track || commit;
        wr_idx  = track ? s_idx : idx_q;
        wr_data = s_data;
    end

    // R1: no write reaches the cells before the synchronized reset releases
    p_no_write_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
        srst |-> !wr_en)
        else $error("p_no_write_in_reset_r1");

    // R8: with chip select low and no write open, nothing is written
    p_cs_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !s_cs) |-> !wr_en)
        else $error("p_cs_gate_r8");
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
    parameter int CELLS = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_data,
    input  logic             view_en,
    input  logic [IDX_W-1:0] view_idx,
    input  logic             view_data,
    output logic [CELLS-1:0] sw_en
);
    logic [CELLS-1:0] cells;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                cells[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                cells[i] <= wr_data;
            end
        end
    end

    // Transparent view of the open cell
    always_comb begin
        sw_en = cells;
        if (view_en) sw_en[view_idx] = view_data;
    end

    // R3: without a write strobe from the controller, every cell holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cells))
        else $error("p_hold_r3");

    // R5: the written cell holds the data of the write cycle
    p_store_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cells[$past(wr_idx)] == $past(wr_data))
        else $error("p_store_r5");

    // R6: a write leaves every other cell unchanged
    p_isolate_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((cells ^ $past(cells)) & ~(CELLS'(1) << $past(wr_idx))) == '0)
        else $error("p_isolate_r6");
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem import xpt_pkg::*; #(
    parameter  int ROW_BITS    = 2,
    parameter  int COL_BITS    = 3,
    parameter  int SYNC_STAGES = 2,
    localparam int ROWS        = 1 << ROW_BITS,
    localparam int COLS        = 1 << COL_BITS,
    localparam int CELLS       = ROWS * COLS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           strobe,
    input  logic                           cs,
    input  logic                           data,
    input  logic [ROW_BITS-1:0]            row_sel,
    input  logic [COL_BITS-1:0]            col_sel,
    output logic [CELLS-1:0]               sw_en,
    output logic [ROWS-1:0][COLS-1:0]      sw_grid
);
    localparam int IDX_W = ROW_BITS + COL_BITS;
    localparam int BW    = 3 + IDX_W;

    logic [BW-1:0]    raw_bus, sync_bus;
    logic             s_strobe, s_cs, s_data, srst;
    logic [IDX_W-1:0] s_idx;
    logic             track, wr_en, wr_data;
    logic [IDX_W-1:0] wr_idx;

    assign raw_bus = {strobe, cs, data, row_sel, col_sel};

    xpt_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (sync_bus)
    );

    xpt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk  (clk),
        .rst  (rst),
        .srst (srst)
    );

    assign {s_strobe, s_cs, s_data, s_idx} = sync_bus;

    xpt_write_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .srst     (srst),
        .s_strobe (s_strobe),
        .s_cs     (s_cs),
        .s_data   (s_data),
        .s_idx    (s_idx),
        .track    (track),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    xpt_cell_array #(.CELLS(CELLS), .IDX_W(IDX_W)) u_cells (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .view_en   (track),
        .view_idx  (s_idx),
        .view_data (s_data),
        .sw_en     (sw_en)
    );

    // Row-by-column view, R2 index rule row*COLS+col
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                sw_grid[r][c] = sw_en[r*COLS + c];
            end
        end
    end

    // R1: outputs read zero whenever reset is sampled high
    always @(posedge clk) begin
        if (rst) begin
            p_clear_all_r1: assert (sw_en == '0)
                else $error("p_clear_all_r1");
        end
    end
endmodule

// File: tb/xpt_ctrl_mem_test.sv
module xpt_ctrl_mem_test;
    localparam int ROWS  = 4;
    localparam int COLS  = 8;
    localparam int CELLS = 32;

    logic clk = 1'b0;
    logic rst, strobe, cs, data;
    logic [1:0] row_sel;
    logic [2:0] col_sel;
    logic [CELLS-1:0] sw_en;
    logic [ROWS-1:0][COLS-1:0] sw_grid;

    always #2 clk = ~clk;

    xpt_ctrl_mem uut (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .cs      (cs),
        .data    (data),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .sw_en   (sw_en),
        .sw_grid (sw_grid)
    );

    typedef struct {
        logic [CELLS-1:0] vec;
        string            tag;
    } exp_t;

    exp_t             sb[$];
    event             chk_ev;
    logic [CELLS-1:0] model;
    int               n_run  = 0;
    int               n_fail = 0;
    bit               done   = 1'b0;

    // Monitor: pops the expected item and compares the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                exp_t it;
                logic [CELLS-1:0] flat;
                it = sb.pop_front();
                for (int r = 0; r < ROWS; r++)
                    for (int c = 0; c < COLS; c++)
                        flat[r*COLS + c] = sw_grid[r][c];
                n_run++;
                if (sw_en !== it.vec || flat !== it.vec) begin
                    n_fail++;
                    $display("FAIL %s: sw_en=%h grid=%h expected=%h",
                             it.tag, sw_en, flat, it.vec);
                end
            end
        end
    end

    // Driver side: let the synchronizers settle, then push and check
    task automatic check(input string tag);
        repeat (6) @(negedge clk);
        sb.push_back('{model, tag});
        ->chk_ev;
        #1;
    endtask

    task automatic wr(input int r, input int c, input bit d, input bit chip);
        @(negedge clk);
        row_sel = r[1:0];
        col_sel = c[2:0];
        data    = d;
        cs      = chip;
        repeat (2) @(negedge clk);
        strobe = 1'b1;
        repeat (4) @(negedge clk);
        strobe = 1'b0;
        repeat (4) @(negedge clk);
        cs = 1'b0;
        if (chip) model[r*COLS + c] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; strobe = 1'b0; cs = 1'b0; data = 1'b0;
        row_sel = '0; col_sel = '0;
        model = '0;
        check("R1 reset state");
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2 R7: every address reaches exactly its own crosspoint
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                wr(r, c, 1'b1, 1'b1);
                check($sformatf("R2 R7 map row%0d col%0d", r, c));
                wr(r, c, 1'b0, 1'b1);
            end
        end
        check("R7 all off after clears");

        // R6: several cells on, then one cleared
        wr(0, 3, 1'b1, 1'b1);
        wr(2, 5, 1'b1, 1'b1);
        wr(3, 7, 1'b1, 1'b1);
        wr(1, 0, 1'b1, 1'b1);
        check("R6 pattern of four");
        wr(2, 5, 1'b0, 1'b1);
        check("R6 single clear keeps others");

        // R8: chip select low blocks the write
        wr(0, 0, 1'b1, 1'b0);
        check("R8 cs low write ignored");
        wr(1, 0, 1'b0, 1'b0);
        check("R8 cs low clear ignored");

        // R3: address and data set, no strobe
        @(negedge clk);
        row_sel = 2'd1; col_sel = 3'd1; data = 1'b1; cs = 1'b1;
        check("R3 no strobe no write");
        cs = 1'b0;

        // R4 R5: transparency and capture on row 1 column 6 (bit 14)
        @(negedge clk);
        row_sel = 2'd1; col_sel = 3'd6; data = 1'b0; cs = 1'b1;
        repeat (2) @(negedge clk);
        strobe = 1'b1;
        check("R4 open with data low");
        data = 1'b1;
        model[14] = 1'b1;
        check("R4 follows data high");
        data = 1'b0;
        model[14] = 1'b0;
        check("R4 follows data low");
        data = 1'b1;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        model[14] = 1'b1;
        check("R5 captured 1 at fall");
        data = 1'b0;
        check("R5 holds after data changes");
        strobe = 1'b1;
        data = 1'b1;
        check("R4 reopen shows 1");
        data = 1'b0;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        model[14] = 1'b0;
        check("R5 captured 0 at fall");
        cs = 1'b0;

        // R1: reset arriving during an open strobe
        @(negedge clk);
        row_sel = 2'd0; col_sel = 3'd4; data = 1'b1; cs = 1'b1;
        repeat (2) @(negedge clk);
        strobe = 1'b1;
        model[4] = 1'b1;
        check("R4 open before reset");
        rst = 1'b1;
        model = '0;
        check("R1 reset during strobe");
        strobe = 1'b0;
        cs = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R1 stays clear after release");

        // R1: reset with chip select low
        wr(3, 2, 1'b1, 1'b1);
        wr(2, 7, 1'b1, 1'b1);
        check("R6 cells set before reset");
        @(negedge clk);
        cs = 1'b0;
        rst = 1'b1;
        model = '0;
        check("R1 reset with cs low");
        rst = 1'b0;
        wr(1, 1, 1'b1, 1'b1);
        check("R3 write after release");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule